// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a set of maskable sources and one non-maskable source and presents a CPU with a single request line and the index of the source that should be served. Every maskable source has its own programmable priority level, its own enable bit and a trigger type (rising edge or level). A global enable bit and a nesting-disable bit sit in a control register. All of these are written through a simple write-only register port.

The controller keeps a stack of the priority levels that are currently in service. When the CPU acknowledges, the level of the chosen source is pushed. When the CPU signals end of interrupt, the top level is popped. A pending source raises the request line only if its level is strictly above the level at the top of the stack, so a handler can be preempted only by something more urgent. Completion unwinds in reverse order, back through the interrupted levels. The non-maskable input ignores every mask and outranks every maskable source. It has a level above all programmable levels, so it preempts any maskable handler but never itself.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the request line is low, the stack is empty, and the global enable, nesting disable, all per-source enables and all priorities are 0. All sources are edge-type.
- R2: An edge-type source becomes pending on a 0-to-1 change of its request input. It stays pending after the input falls, and it is cleared only when the CPU acknowledges that source.
- R3: A level-type source is pending exactly while its request input is high. An acknowledge does not clear it.
- R4: Among eligible maskable sources, the one with the highest priority value wins. On equal priority, the lowest index wins. The vector output is the winning source index.
- R5: A maskable source is eligible only when the global enable (bit 0 at address 0) and its own enable (bit i at address 1) are both 1. While the global enable is 0, no maskable source raises the request line.
- R6: While the stack is not empty, a maskable source raises the request line only if its priority is strictly greater than the top stacked level. Equal or lower levels are held off.
- R7: A rising edge on the non-maskable input makes it pending regardless of all enables, and it outranks every maskable source. Its vector is the number of maskable sources. It preempts any maskable handler, but not a non-maskable handler in service.
- R8: End of interrupt pops the top stacked level, so service eligibility returns to the previously interrupted level. Popping the last entry returns the block to the idle state.
- R9: End of interrupt with an empty stack is ignored.
- R10: With nesting disable (bit 1 at address 0) set, no maskable source raises the request line while the stack is not empty. The non-maskable source still does.
- R11: An acknowledge while the request line is low has no effect. Acknowledge and end of interrupt in the same cycle perform the push only, and the end of interrupt is ignored.
- R12: The trigger type bits are at address 2, with 1 meaning level-type. The priority of source i is held in the low bits of the register at address 8+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Register write data |
| srcReq | input | NUM_SRC | Maskable request inputs |
| nmiReq | input | 1 | Non-maskable request input (edge triggered) |
| cpuAck | input | 1 | CPU acknowledge strobe |
| cpuEoi | input | 1 | CPU end-of-interrupt strobe |
| irq | output | 1 | Interrupt request to the CPU |
| irqVector | output | VEC_W | Index of the source being requested; NUM_SRC for the non-maskable source |

## Verification
The hardest states to reach are three or more stacked levels, followed by unwinding through them while requests sit between the stacked levels. Reaching them needs an ordered chain of acknowledges, with requests raised, dropped and re-prioritised between the pops. The bench walks such a chain explicitly. It also sweeps every priority assignment against every request pattern, and every in-service level against every competing level, using level-type sources so that each pattern can be applied in one cycle. Simultaneous acknowledge and end of interrupt, and end of interrupt on an empty stack, are each followed by a probe whose outcome differs under any other ordering.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int ADDR_CTRL      = 0;
  localparam int ADDR_EN        = 1;
  localparam int ADDR_TYPE      = 2;
  localparam int ADDR_PRIO_BASE = 8;

  typedef struct packed {
    logic push;
    logic pop;
    logic clrSrc;
    logic clrNmi;
  } nirq_strobe_t;
endpackage

// File: rtl/nirq_datapath.sv
module nirq_datapath
  import nirq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int LVL_W     = PRIO_W + 1,
  localparam int DEPTH     = (1 << PRIO_W) + 1,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int SP_W      = $clog2(DEPTH + 1),
  localparam int SRC_IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWe,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic [DATA_W-1:0]                regWdata,
  input  logic [NUM_SRC-1:0]               srcReq,
  input  logic                             nmiReq,
  input  nirq_strobe_t                     ctl,
  input  logic [SRC_IDX_W-1:0]             selIdx,
  input  logic [LVL_W-1:0]                 pushLevel,
  output logic [NUM_SRC-1:0]               pendVec,
  output logic                             nmiPend,
  output logic [NUM_SRC-1:0]               srcEn,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]   srcPrio,
  output logic                             globalEn,
  output logic                             nestDis,
  output logic                             stackEmpty,
  output logic [LVL_W-1:0]                 topLevel
);

  logic [NUM_SRC-1:0] srcLvlType;
  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] edgePend;
  logic               nmiPrev;
  logic [LVL_W-1:0]   lvlStack [DEPTH];
  logic [SP_W-1:0]    sp;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn   <= 1'b0;
      nestDis    <= 1'b0;
      srcEn      <= '0;
      srcLvlType <= '0;
      srcPrio    <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_W'(ADDR_CTRL)) begin
        globalEn <= regWdata[0];
        nestDis  <= regWdata[1];
      end
      if (regAddr == ADDR_W'(ADDR_EN))   srcEn      <= regWdata[NUM_SRC-1:0];
      if (regAddr == ADDR_W'(ADDR_TYPE)) srcLvlType <= regWdata[NUM_SRC-1:0];
      for (int i = 0; i < NUM_SRC; i++) begin
        if (regAddr == ADDR_W'(ADDR_PRIO_BASE + i)) srcPrio[i] <= regWdata[PRIO_W-1:0];
      end
    end
  end

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev  <= '0;
      edgePend <= '0;
      nmiPrev  <= 1'b0;
      nmiPend  <= 1'b0;
    end else begin
      reqPrev <= srcReq;
      nmiPrev <= nmiReq;
      for (int i = 0; i < NUM_SRC; i++) begin
        edgePend[i] <= (edgePend[i] & ~(ctl.clrSrc && selIdx == SRC_IDX_W'(i)))
                     | (srcReq[i] & ~reqPrev[i]);
      end
      nmiPend <= (nmiPend & ~ctl.clrNmi) | (nmiReq & ~nmiPrev);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      pendVec[i] = srcLvlType[i] ? srcReq[i] : edgePend[i];
    end
  end

  // in-service level stack
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp <= '0;
    end else if (ctl.push) begin
      lvlStack[IDX_W'(sp)] <= pushLevel;
      sp <= sp + SP_W'(1);
    end else if (ctl.pop) begin
      sp <= sp - SP_W'(1);
    end
  end

  assign stackEmpty = (sp == '0);
  assign topLevel   = stackEmpty ? '0 : lvlStack[IDX_W'(sp - SP_W'(1))];

  // R6
  stack_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && !stackEmpty) |-> (pushLevel > topLevel));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> (sp < SP_W'(DEPTH)));

  // R8
  pop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |=> (sp == $past(sp) - SP_W'(1)));

  // R9
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> !stackEmpty);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_holdChk
    // R2
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (edgePend[g] && !(ctl.clrSrc && selIdx == SRC_IDX_W'(g))) |=> edgePend[g]);
  end

endmodule

// File: rtl/nirq_control.sv
module nirq_control
  import nirq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 2,
  localparam int LVL_W     = PRIO_W + 1,
  localparam int VEC_W     = $clog2(NUM_SRC + 1),
  localparam int SRC_IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(1 << PRIO_W)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cpuAck,
  input  logic                           cpuEoi,
  input  logic [NUM_SRC-1:0]             pendVec,
  input  logic                           nmiPend,
  input  logic [NUM_SRC-1:0]             srcEn,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] srcPrio,
  input  logic                           globalEn,
  input  logic                           nestDis,
  input  logic                           stackEmpty,
  input  logic [LVL_W-1:0]               topLevel,
  output nirq_strobe_t                   ctl,
  output logic [SRC_IDX_W-1:0]           selIdx,
  output logic [LVL_W-1:0]               pushLevel,
  output logic                           irq,
  output logic [VEC_W-1:0]               irqVector
);

  logic              found;
  logic [PRIO_W-1:0] bestPrio;
  logic              nmiInSvc;
  logic              nmiFire;
  logic              maskFire;
  logic              take;

  // highest priority, lowest index on ties
  always_comb begin
    found    = 1'b0;
    selIdx   = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendVec[i] && srcEn[i] && globalEn) begin
        if (!found || srcPrio[i] > bestPrio) begin
          found    = 1'b1;
          selIdx   = SRC_IDX_W'(i);
          bestPrio = srcPrio[i];
        end
      end
    end
  end

  assign nmiInSvc = !stackEmpty && (topLevel == NMI_LVL);
  assign nmiFire  = nmiPend && !nmiInSvc;
  assign maskFire = found && (stackEmpty || (!nestDis && ({1'b0, bestPrio} > topLevel)));
  assign irq      = nmiFire || maskFire;
  assign irqVector = nmiFire ? VEC_W'(NUM_SRC) : VEC_W'(selIdx);
  assign pushLevel = nmiFire ? NMI_LVL : {1'b0, bestPrio};
  assign take      = cpuAck && irq;

  always_comb begin
    ctl        = '0;
    ctl.push   = take;
    ctl.clrNmi = take && nmiFire;
    ctl.clrSrc = take && !nmiFire;
    ctl.pop    = cpuEoi && !take && !stackEmpty;
  end

  // R5
  mask_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn && irq) |-> (irqVector == VEC_W'(NUM_SRC)));

  // R9
  empty_eoi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuEoi && !cpuAck && stackEmpty) |=> stackEmpty);

  // R7
  nmi_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && irq && irqVector == VEC_W'(NUM_SRC)) |=> (!stackEmpty && topLevel == NMI_LVL));

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && !irq && !cpuEoi) |=> (stackEmpty == $past(stackEmpty)));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int VEC_W     = $clog2(NUM_SRC + 1),
  localparam int LVL_W     = PRIO_W + 1,
  localparam int SRC_IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               nmiReq,
  input  logic               cpuAck,
  input  logic               cpuEoi,
  output logic               irq,
  output logic [VEC_W-1:0]   irqVector
);

  nirq_strobe_t                   ctl;
  logic [SRC_IDX_W-1:0]           selIdx;
  logic [LVL_W-1:0]               pushLevel;
  logic [NUM_SRC-1:0]             pendVec;
  logic                           nmiPend;
  logic [NUM_SRC-1:0]             srcEn;
  logic [NUM_SRC-1:0][PRIO_W-1:0] srcPrio;
  logic                           globalEn;
  logic                           nestDis;
  logic                           stackEmpty;
  logic [LVL_W-1:0]               topLevel;

  nirq_datapath #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .srcReq(srcReq), .nmiReq(nmiReq), .ctl(ctl), .selIdx(selIdx), .pushLevel(pushLevel),
    .pendVec(pendVec), .nmiPend(nmiPend), .srcEn(srcEn), .srcPrio(srcPrio),
    .globalEn(globalEn), .nestDis(nestDis), .stackEmpty(stackEmpty), .topLevel(topLevel)
  );

  nirq_control #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .cpuAck(cpuAck), .cpuEoi(cpuEoi),
    .pendVec(pendVec), .nmiPend(nmiPend), .srcEn(srcEn), .srcPrio(srcPrio),
    .globalEn(globalEn), .nestDis(nestDis), .stackEmpty(stackEmpty), .topLevel(topLevel),
    .ctl(ctl), .selIdx(selIdx), .pushLevel(pushLevel), .irq(irq), .irqVector(irqVector)
  );

endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
  localparam int NSRC = 4;
  localparam int NMIV = NSRC;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWe;
  logic [3:0] regAddr;
  logic [7:0] regWdata;
  logic [3:0] srcReq;
  logic       nmiReq;
  logic       cpuAck;
  logic       cpuEoi;
  logic       irq;
  logic [2:0] irqVector;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  nest_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .srcReq(srcReq), .nmiReq(nmiReq), .cpuAck(cpuAck), .cpuEoi(cpuEoi),
    .irq(irq), .irqVector(irqVector)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    regWe = 1'b1; regAddr = 4'(a); regWdata = 8'(d);
    step();
    regWe = 1'b0;
  endtask

  task automatic ack();
    cpuAck = 1'b1; step(); cpuAck = 1'b0;
  endtask

  task automatic eoi();
    cpuEoi = 1'b1; step(); cpuEoi = 1'b0;
  endtask

  task automatic nmiPulse();
    nmiReq = 1'b1; step(); nmiReq = 1'b0;
  endtask

  task automatic look(input string tag, input int eIrq, input int eVec);
    #1;
    nChecks++;
    if (int'(irq) != eIrq || (eIrq == 1 && int'(irqVector) != eVec)) begin
      nFails++;
      $display("FAIL %s: irq=%0d vec=%0d expected irq=%0d vec=%0d",
               tag, irq, irqVector, eIrq, eVec);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    srcReq = '0; nmiReq = 1'b0; cpuAck = 1'b0; cpuEoi = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  // winner index for request mask m and priority code pc (2 bits per source), -1 if none
  function automatic int winner(input int pc, input int m);
    int best = -1;
    int bp = -1;
    for (int i = 0; i < NSRC; i++) begin
      if ((m >> i) & 1) begin
        if (((pc >> (2*i)) & 3) > bp) begin
          bp = (pc >> (2*i)) & 3;
          best = i;
        end
      end
    end
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 reset state and defaults
    doReset();
    look("R1 idle after reset", 0, 0);
    wr(0, 1); wr(1, 'hF);
    look("R1 no request", 0, 0);
    srcReq = 4'b1010; step();
    look("R1 equal default prio, lowest index", 1, 1);
    srcReq = 4'b0000; step();
    look("R1 default edge type holds", 1, 1);

    // R4 R12 exhaustive priority sweep, level-type sources
    doReset();
    wr(0, 1); wr(1, 'hF); wr(2, 'hF);
    for (int pc = 0; pc < 256; pc++) begin
      for (int s = 0; s < NSRC; s++) wr(8 + s, (pc >> (2*s)) & 3);
      for (int m = 0; m < 16; m++) begin
        int w;
        srcReq = 4'(m);
        w = winner(pc, m);
        look("R4 R12 priority sweep", (w >= 0) ? 1 : 0, w);
      end
    end

    // R5 enable sweep, equal priorities
    doReset();
    wr(0, 1); wr(2, 'hF);
    for (int en = 0; en < 16; en++) begin
      wr(1, en);
      for (int m = 0; m < 16; m++) begin
        int w;
        srcReq = 4'(m);
        w = winner(0, m & en);
        look("R5 per-source enable", (w >= 0) ? 1 : 0, w);
      end
    end
    wr(1, 'hF); wr(0, 0);
    for (int m = 1; m < 16; m++) begin
      srcReq = 4'(m);
      look("R5 global enable off", 0, 0);
    end

    // R2 edge latch
    doReset();
    wr(0, 1); wr(1, 'hF); wr(10, 2);
    srcReq = 4'b0100; step();
    srcReq = 4'b0000; step();
    look("R2 edge pending held", 1, 2);
    step(); step(); step();
    look("R2 still pending", 1, 2);
    ack();
    look("R2 cleared by ack", 0, 0);
    eoi();
    look("R2 stays clear after eoi", 0, 0);

    // R3 level type
    doReset();
    wr(0, 1); wr(1, 'hF); wr(2, 2);
    srcReq = 4'b0010; step();
    look("R3 level pending", 1, 1);
    ack();
    look("R3 same level held off", 0, 0);
    eoi();
    look("R3 not cleared by ack", 1, 1);
    srcReq = 4'b0000;
    look("R3 follows input low", 0, 0);

    // R6 R8 in-service level vs competing level sweep
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < 4; p++) begin
        doReset();
        wr(0, 1); wr(1, 'hF); wr(2, 'hF); wr(8, t); wr(9, p);
        srcReq = 4'b0001; step();
        look("R6 first request", 1, 0);
        ack();
        srcReq = 4'b0011; step();
        look("R6 preempt only if higher", (p > t) ? 1 : 0, 1);
        eoi();
        look("R8 idle after pop", 1, (p > t) ? 1 : 0);
      end
    end

    // R8 R9 three-deep nesting and unwind
    doReset();
    wr(0, 1); wr(1, 'hF); wr(2, 'hF); wr(8, 1); wr(9, 2); wr(10, 3); wr(11, 0);
    srcReq = 4'b0001; step();
    look("R8 level1 request", 1, 0);
    ack();
    srcReq = 4'b0011; step();
    look("R8 level2 preempts", 1, 1);
    ack();
    srcReq = 4'b0111; step();
    look("R8 level3 preempts", 1, 2);
    ack();
    look("R6 all held at top level 3", 0, 0);
    wr(11, 2);
    srcReq = 4'b1001; step();
    look("R6 level2 held under 3", 0, 0);
    eoi();
    look("R8 back to level2, equal held", 0, 0);
    eoi();
    look("R8 back to level1, level2 fires", 1, 3);
    eoi();
    look("R8 empty, highest wins", 1, 3);
    eoi(); eoi();
    look("R9 eoi on empty ignored", 1, 3);
    ack();
    look("R9 one entry after empty eois", 0, 0);
    eoi();
    look("R9 single pop empties", 1, 3);

    // R7 non-maskable
    doReset();
    nmiPulse();
    look("R7 nmi with all masks off", 1, NMIV);
    wr(0, 1); wr(1, 'hF); wr(8, 3);
    srcReq = 4'b0001; step();
    look("R7 nmi beats prio3", 1, NMIV);
    ack();
    look("R7 maskable held under nmi", 0, 0);
    nmiPulse();
    look("R7 nmi does not preempt nmi", 0, 0);
    eoi();
    look("R7 second nmi after pop", 1, NMIV);
    ack(); eoi();
    look("R7 maskable after nmi done", 1, 0);
    ack(); eoi();
    look("R2 edge source consumed", 0, 0);

    // R10 nesting disable
    doReset();
    wr(0, 3); wr(1, 'hF); wr(2, 'hF); wr(8, 0); wr(9, 3);
    srcReq = 4'b0001; step();
    look("R10 first request", 1, 0);
    ack();
    srcReq = 4'b0011; step();
    look("R10 no maskable nesting", 0, 0);
    nmiPulse();
    look("R10 nmi still nests", 1, NMIV);
    ack(); eoi();
    look("R10 back under level0, blocked", 0, 0);
    wr(0, 1);
    look("R10 cleared bit allows preempt", 1, 1);

    // R11 ack while idle, ack with eoi
    doReset();
    wr(0, 1); wr(1, 'hF); wr(2, 'hF);
    ack();
    srcReq = 4'b0001; step();
    look("R11 idle ack pushed nothing", 1, 0);
    wr(8, 1); wr(9, 2);
    ack();
    srcReq = 4'b0011; step();
    look("R11 level2 pending", 1, 1);
    cpuAck = 1'b1; cpuEoi = 1'b1; step(); cpuAck = 1'b0; cpuEoi = 1'b0;
    srcReq = 4'b0001;
    look("R11 push wins over eoi", 0, 0);
    eoi();
    look("R11 level1 still stacked", 0, 0);
    eoi();
    look("R11 empty after two pops", 1, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule